// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This block sequences an in-order stream of vector instructions onto three fixed-latency vector units: a load unit, a multiplier and an adder. Each instruction names a destination register and, for arithmetic operations, two source registers. The controller starts an instruction on its unit as soon as every hazard is cleared. It pulses that unit's start line and then tracks, register by register, how many elements have been written so far.

When the chaining mode input is high, a consumer may start once the first element of each source has landed. Its element reads then trail the producer's writes by at least one element. When the mode input is low, a consumer waits until the producer has written the whole vector. Each unit reads one element per cycle for the full vector length. After its last read it observes a parameterised dead time before it accepts another instruction. Instructions for different units overlap freely. A free-running counter of active cycles lets a testbench compare the chained and unchained runtimes of the same instruction sequence.

Data values and memory contents are not modelled. Only the timing of element reads and writes is.

Top module: `vchain_issue_ctrl`

## Requirements
- R1: After reset every register's written-element count equals the vector length (32), `busy` is low, `cycle_cnt` is zero and `in_ready` is high.
- R2: Operation code 0 selects the load unit, 1 the multiplier, and 2 or 3 the adder; the load uses no sources. An accepted instruction (`in_valid` and `in_ready` both high) pulses exactly the selected unit's start output in that same cycle.
- R3: With `chain_en` high, a dependent instruction starts LAT+1 cycles after its producer started, where LAT is the producer's latency (load 12, multiply 6, add 1).
- R4: With `chain_en` low, a dependent instruction starts LAT+32 cycles after its producer started, once all 32 elements are written.
- R5: An instruction that is independent of earlier ones and targets a different, free unit starts in the cycle after the previous one.
- R6: Two instructions on the same unit start at least 32+DEAD cycles apart, where DEAD is the dead time (default 4).
- R7: After an instruction with destination d starts in cycle t, the count for d reads 0 up to cycle t+LAT. From cycle t+LAT+1+k it reads k+1, and it never exceeds 32. Element k of d is valid exactly when the count exceeds k.
- R8: An instruction whose destination is a source of a unit still reading waits until that unit has finished its reads.
- R9: An instruction whose destination still has writes outstanding waits until that register's count reaches 32. This holds in either mode.
- R10: `cycle_cnt` increases by one in each cycle in which `in_valid` or `busy` is high. `busy` is high while any unit is still reading or has elements in its pipeline.
- R11: A unit reads element k of a source register only after element k of that register has been written.

Element counts are held in an array of per-register counters, one per architectural vector register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Head instruction present |
| in_op | input | 2 | Operation: 0 load, 1 multiply, 2/3 add |
| in_vd | input | 3 | Destination register |
| in_vs1 | input | 3 | First source register |
| in_vs2 | input | 3 | Second source register |
| chain_en | input | 1 | 1: element-level chaining, 0: whole-vector wait |
| in_ready | output | 1 | Head instruction may start this cycle |
| start_ld | output | 1 | Load unit starts |
| start_mul | output | 1 | Multiplier starts |
| start_add | output | 1 | Adder starts |
| vreg_cnt | output | 48 | Written-element count per register, 6 bits each, register r at bits [6r+5:6r] |
| busy | output | 1 | Some unit reading or draining |
| cycle_cnt | output | 16 | Active-cycle counter |

## Verification
Several properties are checked on every cycle: a unit never starts while reading or in its dead time, and at most one start fires per cycle. They also cover counts that never overrun the vector length, no two units writing the same register at once, and every chained element read trailing its source's written count. The exact start spacing is shown only by the scenarios. These are LAT+1 when chained, LAT+32 when unchained, one cycle for independent work, 32+DEAD on a shared unit, and the stalls for reuse-before-read and overlapping writes. The total active-cycle figures that contrast the two modes, and the exact cycle in which each count steps, likewise come only from the scenarios.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_MUL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_ADD2 = 2'd3
  } vop_e;

  localparam int NUM_UNITS = 3;
  localparam int U_LD  = 0;
  localparam int U_MUL = 1;
  localparam int U_ADD = 2;
endpackage

// File: rtl/vchain_unit.sv
module vchain_unit #(
  parameter int VLEN = 32,
  parameter int LAT  = 1,
  parameter int DEAD = 4,
  parameter int REGW = 3,
  localparam int CNTW = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [REGW-1:0] vd_i,
  input  logic [REGW-1:0] vs1_i,
  input  logic [REGW-1:0] vs2_i,
  output logic            free_o,
  output logic            reading_o,
  output logic [CNTW-1:0] rd_idx_o,
  output logic [REGW-1:0] vd_o,
  output logic [REGW-1:0] vs1_o,
  output logic [REGW-1:0] vs2_o,
  output logic            wr_en_o,
  output logic [REGW-1:0] wr_vd_o,
  output logic            busy_o
);
  localparam int DW = (DEAD > 0) ? $clog2(DEAD + 1) : 1;

  logic [CNTW-1:0] rd_cnt_q, rd_cnt_d;
  logic [DW-1:0]   dead_q, dead_d;
  logic [REGW-1:0] vd_q, vs1_q, vs2_q;
  logic [LAT-1:0]  pv_q, pv_d;
  logic [LAT-1:0][REGW-1:0] pd_q, pd_d;
  logic read_now, last_read;

  // next state
  always_comb begin
    read_now  = issue_i | (rd_cnt_q != '0);
    last_read = issue_i ? (VLEN == 1) : (rd_cnt_q == CNTW'(1));
    rd_cnt_d  = rd_cnt_q;
    if (issue_i)
      rd_cnt_d = CNTW'(VLEN - 1);
    else if (rd_cnt_q != '0)
      rd_cnt_d = rd_cnt_q - CNTW'(1);
    dead_d = dead_q;
    if (read_now && last_read)
      dead_d = DW'(DEAD);
    else if (dead_q != '0)
      dead_d = dead_q - DW'(1);
    pv_d = pv_q;
    pd_d = pd_q;
    for (int i = LAT - 1; i > 0; i--) begin
      pv_d[i] = pv_q[i-1];
      pd_d[i] = pd_q[i-1];
    end
    pv_d[0] = read_now;
    pd_d[0] = issue_i ? vd_i : vd_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q <= '0;
      dead_q   <= '0;
      pv_q     <= '0;
    end else begin
      rd_cnt_q <= rd_cnt_d;
      dead_q   <= dead_d;
      pv_q     <= pv_d;
    end
  end

  // operand registers, loaded on issue
  always_ff @(posedge clk) begin
    if (issue_i) begin
      vd_q  <= vd_i;
      vs1_q <= vs1_i;
      vs2_q <= vs2_i;
    end
  end

  // destination tags travel with the pipeline
  always_ff @(posedge clk) begin
    pd_q <= pd_d;
  end

  assign free_o    = (rd_cnt_q == '0) && (dead_q == '0);
  assign reading_o = (rd_cnt_q != '0);
  assign rd_idx_o  = CNTW'(VLEN) - rd_cnt_q;
  assign vd_o      = vd_q;
  assign vs1_o     = vs1_q;
  assign vs2_o     = vs2_q;
  assign wr_en_o   = pv_q[LAT-1];
  assign wr_vd_o   = pd_q[LAT-1];
  assign busy_o    = reading_o | (|pv_q);

  assert_issue_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> free_o);
  assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEAD > 0) && reading_o && (rd_cnt_q == CNTW'(1))) |=> !free_o);
  assert_read_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q < CNTW'(VLEN));
endmodule

// File: rtl/vchain_score.sv
module vchain_score #(
  parameter int NREG = 8,
  parameter int VLEN = 32,
  parameter int REGW = 3,
  parameter int NU   = 3,
  localparam int CNTW = $clog2(VLEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic [REGW-1:0]           clr_idx_i,
  input  logic [NU-1:0]             wr_en_i,
  input  logic [NU-1:0][REGW-1:0]   wr_vd_i,
  output logic [NREG*CNTW-1:0]      cnt_flat_o
);
  logic [CNTW-1:0] cnt_q [NREG];
  logic [CNTW-1:0] cnt_d [NREG];
  logic [NU-1:0]   hit   [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      for (int u = 0; u < NU; u++)
        hit[r][u] = wr_en_i[u] && (wr_vd_i[u] == REGW'(r));
      if (clr_i && (clr_idx_i == REGW'(r)))
        cnt_d[r] = '0;
      else if (|hit[r])
        cnt_d[r] = cnt_q[r] + CNTW'(1);
      else
        cnt_d[r] = cnt_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cnt_q[r] <= CNTW'(VLEN);
    end else begin
      for (int r = 0; r < NREG; r++) cnt_q[r] <= cnt_d[r];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_out
    assign cnt_flat_o[r*CNTW +: CNTW] = cnt_q[r];
    assert_single_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit[r]));
  end

  for (genvar u = 0; u < NU; u++) begin : g_chk
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i[u] |-> (cnt_q[wr_vd_i[u]] < CNTW'(VLEN)));
  end
endmodule

// File: rtl/vchain_hazard.sv
module vchain_hazard
  import vchain_pkg::*;
#(
  parameter int NREG = 8,
  parameter int VLEN = 32,
  parameter int REGW = 3,
  parameter int NU   = 3,
  localparam int CNTW = $clog2(VLEN + 1)
) (
  input  logic [1:0]              op_i,
  input  logic [REGW-1:0]         vd_i,
  input  logic [REGW-1:0]         vs1_i,
  input  logic [REGW-1:0]         vs2_i,
  input  logic                    chain_en_i,
  input  logic [NREG*CNTW-1:0]    cnt_flat_i,
  input  logic [NU-1:0]           u_free_i,
  input  logic [NU-1:0]           u_reading_i,
  input  logic [NU-1:0][REGW-1:0] u_vs1_i,
  input  logic [NU-1:0][REGW-1:0] u_vs2_i,
  output logic [NU-1:0]           unit_sel_o,
  output logic                    ready_o
);
  logic [CNTW-1:0] c_vd, c_s1, c_s2;
  logic needs_src, ok1, ok2, waw_ok, war_ok, unit_ok;

  always_comb begin
    unit_sel_o = '0;
    case (vop_e'(op_i))
      OP_LOAD: unit_sel_o[U_LD]  = 1'b1;
      OP_MUL:  unit_sel_o[U_MUL] = 1'b1;
      default: unit_sel_o[U_ADD] = 1'b1;
    endcase
    needs_src = (vop_e'(op_i) != OP_LOAD);
    c_vd = cnt_flat_i[int'(vd_i)*CNTW +: CNTW];
    c_s1 = cnt_flat_i[int'(vs1_i)*CNTW +: CNTW];
    c_s2 = cnt_flat_i[int'(vs2_i)*CNTW +: CNTW];
    ok1  = chain_en_i ? (c_s1 != '0) : (c_s1 == CNTW'(VLEN));
    ok2  = chain_en_i ? (c_s2 != '0) : (c_s2 == CNTW'(VLEN));
    waw_ok = (c_vd == CNTW'(VLEN));
    war_ok = 1'b1;
    for (int u = 0; u < NU; u++) begin
      if ((u != U_LD) && u_reading_i[u] &&
          ((u_vs1_i[u] == vd_i) || (u_vs2_i[u] == vd_i)))
        war_ok = 1'b0;
    end
    unit_ok = |(unit_sel_o & u_free_i);
    ready_o = unit_ok && waw_ok && war_ok && (!needs_src || (ok1 && ok2));
  end
endmodule

// File: rtl/vchain_issue_ctrl.sv
module vchain_issue_ctrl
  import vchain_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int VLEN    = 32,
  parameter int LAT_LD  = 12,
  parameter int LAT_MUL = 6,
  parameter int LAT_ADD = 1,
  parameter int DEAD    = 4,
  parameter int CYCW    = 16,
  localparam int REGW = $clog2(NREG),
  localparam int CNTW = $clog2(VLEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_op,
  input  logic [REGW-1:0]        in_vd,
  input  logic [REGW-1:0]        in_vs1,
  input  logic [REGW-1:0]        in_vs2,
  input  logic                   chain_en,
  output logic                   in_ready,
  output logic                   start_ld,
  output logic                   start_mul,
  output logic                   start_add,
  output logic [NREG*CNTW-1:0]   vreg_cnt,
  output logic                   busy,
  output logic [CYCW-1:0]        cycle_cnt
);
  localparam int NU = NUM_UNITS;

  logic [NU-1:0]           unit_sel, start, u_free, u_reading, u_wr_en, u_busy;
  logic [NU-1:0][REGW-1:0] u_vd, u_vs1, u_vs2, u_wr_vd;
  logic [NU-1:0][CNTW-1:0] u_rd_idx;
  logic                    accept;
  logic [CYCW-1:0]         cyc_q, cyc_d;
  logic [CNTW-1:0]         cnt_arr [NREG];

  vchain_hazard #(.NREG(NREG), .VLEN(VLEN), .REGW(REGW), .NU(NU)) u_hazard (
    .op_i        (in_op),
    .vd_i        (in_vd),
    .vs1_i       (in_vs1),
    .vs2_i       (in_vs2),
    .chain_en_i  (chain_en),
    .cnt_flat_i  (vreg_cnt),
    .u_free_i    (u_free),
    .u_reading_i (u_reading),
    .u_vs1_i     (u_vs1),
    .u_vs2_i     (u_vs2),
    .unit_sel_o  (unit_sel),
    .ready_o     (in_ready)
  );

  assign accept = in_valid && in_ready;
  assign start  = unit_sel & {NU{accept}};

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int ULAT = (u == U_LD) ? LAT_LD : ((u == U_MUL) ? LAT_MUL : LAT_ADD);
    vchain_unit #(.VLEN(VLEN), .LAT(ULAT), .DEAD(DEAD), .REGW(REGW)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_i   (start[u]),
      .vd_i      (in_vd),
      .vs1_i     (in_vs1),
      .vs2_i     (in_vs2),
      .free_o    (u_free[u]),
      .reading_o (u_reading[u]),
      .rd_idx_o  (u_rd_idx[u]),
      .vd_o      (u_vd[u]),
      .vs1_o     (u_vs1[u]),
      .vs2_o     (u_vs2[u]),
      .wr_en_o   (u_wr_en[u]),
      .wr_vd_o   (u_wr_vd[u]),
      .busy_o    (u_busy[u])
    );
  end

  vchain_score #(.NREG(NREG), .VLEN(VLEN), .REGW(REGW), .NU(NU)) u_score (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .clr_idx_i  (in_vd),
    .wr_en_i    (u_wr_en),
    .wr_vd_i    (u_wr_vd),
    .cnt_flat_o (vreg_cnt)
  );

  assign start_ld  = start[U_LD];
  assign start_mul = start[U_MUL];
  assign start_add = start[U_ADD];
  assign busy      = |u_busy;

  // active-cycle counter, saturating
  always_comb begin
    cyc_d = cyc_q;
    if ((in_valid || busy) && (cyc_q != '1))
      cyc_d = cyc_q + CYCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  assign cycle_cnt = cyc_q;

  for (genvar r = 0; r < NREG; r++) begin : g_cnt
    assign cnt_arr[r] = vreg_cnt[r*CNTW +: CNTW];
  end

  assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));

  for (genvar u = 1; u < NU; u++) begin : g_raw
    assert_src1_written_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (u_reading[u] && (u_vs1[u] != u_vd[u])) |-> (cnt_arr[u_vs1[u]] > u_rd_idx[u]));
    assert_src2_written_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (u_reading[u] && (u_vs2[u] != u_vd[u])) |-> (cnt_arr[u_vs2[u]] > u_rd_idx[u]));
  end
endmodule

// File: tb/vchain_issue_ctrl_tb.sv
module vchain_issue_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [2:0]  in_vd, in_vs1, in_vs2;
  logic        chain_en;
  logic        in_ready, start_ld, start_mul, start_add, busy;
  logic [47:0] vreg_cnt;
  logic [15:0] cycle_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int t_ld, t_mul, t_add0, t_add1, n_add;

  always #5 clk = ~clk;

  vchain_issue_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2), .chain_en(chain_en),
    .in_ready(in_ready), .start_ld(start_ld), .start_mul(start_mul),
    .start_add(start_add), .vreg_cnt(vreg_cnt), .busy(busy), .cycle_cnt(cycle_cnt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // record start cycles away from the edge
  always @(negedge clk) begin
    #2;
    if (start_ld)  t_ld  = cyc;
    if (start_mul) t_mul = cyc;
    if (start_add) begin
      if (n_add == 0) t_add0 = cyc;
      t_add1 = cyc;
      n_add++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int r);
    return int'(vreg_cnt[r*6 +: 6]);
  endfunction

  task automatic do_reset(input logic chain);
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0;
    in_vd = 3'd0; in_vs1 = 3'd0; in_vs2 = 3'd0; chain_en = chain;
    n_add = 0; t_ld = -1; t_mul = -1; t_add0 = -1; t_add1 = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int vd, input int s1, input int s2);
    @(negedge clk);
    in_valid = 1'b1; in_op = op;
    in_vd = 3'(vd); in_vs1 = 3'(s1); in_vs2 = 3'(s2);
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic finish_stream();
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    while (busy) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    #2;
    for (int r = 0; r < 8; r++) check("R1 count", cnt_of(r), 32);
    check("R1 busy", int'(busy), 0);
    check("R1 cycle_cnt", int'(cycle_cnt), 0);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_chained();
    do_reset(1'b1);
    issue(2'd0, 1, 0, 0);
    issue(2'd1, 3, 1, 2);
    issue(2'd2, 5, 3, 4);
    finish_stream();
    check("R3 load->mul gap", t_mul - t_ld, 13);
    check("R3 R11 mul->add gap", t_add0 - t_mul, 7);
    check("R10 chained cycles", int'(cycle_cnt), 53);
  endtask

  task automatic t_unchained();
    do_reset(1'b0);
    issue(2'd0, 1, 0, 0);
    issue(2'd1, 3, 1, 2);
    issue(2'd3, 5, 3, 4);
    finish_stream();
    check("R4 load->mul gap", t_mul - t_ld, 44);
    check("R4 mul->add gap", t_add0 - t_mul, 38);
    check("R10 unchained cycles", int'(cycle_cnt), 115);
  endtask

  task automatic t_independent();
    do_reset(1'b1);
    issue(2'd0, 1, 0, 0);
    issue(2'd2, 2, 3, 4);
    finish_stream();
    check("R5 independent gap", t_add0 - t_ld, 1);
    check("R2 add start count", n_add, 1);
  endtask

  task automatic t_dead();
    do_reset(1'b1);
    issue(2'd2, 1, 2, 3);
    issue(2'd2, 4, 5, 6);
    finish_stream();
    check("R6 same-unit gap", t_add1 - t_add0, 36);
    check("R10 dead-time cycles", int'(cycle_cnt), 69);
  endtask

  task automatic t_elements();
    do_reset(1'b1);
    issue(2'd0, 1, 0, 0);
    @(negedge clk); in_valid = 1'b0; #2;
    check("R7 count after start", cnt_of(1), 0);
    repeat (11) @(negedge clk); #2;
    check("R7 count at t+12", cnt_of(1), 0);
    @(negedge clk); #2;
    check("R7 count at t+13", cnt_of(1), 1);
    repeat (7) @(negedge clk); #2;
    check("R7 count at t+20", cnt_of(1), 8);
    finish_stream();
    check("R7 count done", cnt_of(1), 32);
    issue(2'd0, 1, 0, 0);
    @(negedge clk); in_valid = 1'b0; #2;
    check("R7 count cleared on restart", cnt_of(1), 0);
    finish_stream();
  endtask

  task automatic t_war();
    do_reset(1'b1);
    issue(2'd2, 2, 1, 3);
    issue(2'd0, 1, 0, 0);
    finish_stream();
    check("R8 reuse-before-read gap", t_ld - t_add0, 32);
  endtask

  task automatic t_waw();
    do_reset(1'b1);
    issue(2'd1, 1, 2, 3);
    issue(2'd2, 1, 4, 5);
    finish_stream();
    check("R9 overlapping-write gap", t_add0 - t_mul, 38);
  endtask

  initial begin
    t_reset();
    t_chained();
    t_unchained();
    t_independent();
    t_dead();
    t_elements();
    t_war();
    t_waw();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule